// File: doc/BRIEF.md
# Page-Buffered Flash Write Controller

This block models the host side of a word-wide, page-programmed nonvolatile memory. A host on a simple synchronous bus loads 16-bit words into a 128-word page buffer. The first write opens a load window and fixes the target page. Later writes to the same page may arrive in any order. Each accepted write restarts an idle timer. When the timer expires with no further write, the window closes and a timed programming cycle starts. That cycle commits the whole page to the array in one step, and any word not loaded is stored as all ones.

While programming runs, `busy` is high and writes are ignored. A read during that time does not return array contents. It returns a status word built from the last word loaded: its two polling bits are inverted and its two toggle bits alternate on each read. Software can therefore detect the end of programming without watching `busy`.

The idle timeout and the programming time are parameters in clock cycles. The array keeps `2**ARR_PG_W` pages. Page addresses alias onto their low `ARR_PG_W` bits, which keeps the model small.

Top module: `pgw_flash_wctl`

## Requirements
- R1: Address bits 6..0 select the word within a page and bits 15..7 select the page. The array stores a page at index `page mod 2**ARR_PG_W`, so page addresses that differ only above that range read the same data.
- R2: Words of one window may be loaded in any order. If a word is loaded twice, the later load is the one programmed.
- R3: A write in an open window whose page (bits 15..7) differs from the window's first word is ignored. It also raises `page_err`, which stays high until reset.
- R4: `busy` rises exactly LOAD_TO clock cycles after the rising edge that accepted the last write, counted in edges. A write accepted earlier restarts the count.
- R5: After programming, every word of the page that was not loaded in the window reads FFFFh.
- R6: `busy` stays high for exactly PROG_CYC cycles. When it falls, the array already holds the new page.
- R7: A read while `busy` is high returns the last loaded word with bits 15 and 7 inverted. Bits 13..8 and 5..0 are returned unchanged.
- R8: In that status word, bits 14 and 6 are equal. They read 0 on the first read of a programming cycle and invert on each further read in that cycle.
- R9: A write while `busy` is high has no effect on the array.
- R10: `rdata` takes its new value on the clock edge that samples `rd_en`. It holds its value in every cycle without a read.
- R11: After reset, `busy`, `page_err` and `rdata` are 0 and every array word reads FFFFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Word load strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 16 | Word address: page in bits 15..7, word in bits 6..0 |
| wdata | input | 16 | Word to load |
| rdata | output | 16 | Read result, or the status word while busy |
| busy | output | 1 | Programming cycle in progress |
| page_err | output | 1 | Sticky flag for a load to a different page |

## Verification
Faults in the window timer show up at the edge where `busy` rises. That edge moves by at least one cycle relative to the last accepted write, so the bench checks `busy` on the cycle before and the cycle of the expected rise. A stale page latch or a fault in a buffer valid bit does not show until a full program cycle later, when the readback differs from the loaded value or from FFFFh. A fault in the polling or toggle logic shows on the first or second read during programming.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgw_state_e;
endpackage

// File: rtl/pgw_timer.sv
// Cycle counter: clears on clr, advances while en, flags the final cycle.
module pgw_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pgw_page_buf.sv
// Page buffer with per-word valid flags; unloaded words present as all ones.
module pgw_page_buf #(
  parameter int DATA_W = 16,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [PAGE_W-1:0] ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              clr,
  output logic [DATA_W-1:0] img [1<<PAGE_W]
);
  localparam int WORDS = 1 << PAGE_W;
  logic [DATA_W-1:0] word_q [WORDS];
  logic [WORDS-1:0]  vld_q;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic sel;
    assign sel = ld_en && (ld_idx == PAGE_W'(i));

    always_ff @(posedge clk) begin
      if (sel) word_q[i] <= ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q[i] <= 1'b0;
      else if (clr) vld_q[i] <= 1'b0;
      else if (sel) vld_q[i] <= 1'b1;
    end

    assign img[i] = vld_q[i] ? word_q[i] : '1;
  end
endmodule

// File: rtl/pgw_array.sv
// Storage array: whole-page commit, asynchronous word read, erased at reset.
module pgw_array #(
  parameter int DATA_W   = 16,
  parameter int PAGE_W   = 7,
  parameter int ARR_PG_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit,
  input  logic [ARR_PG_W-1:0]        commit_pg,
  input  logic [DATA_W-1:0]          img [1<<PAGE_W],
  input  logic [ARR_PG_W+PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0]          rd_word
);
  localparam int WORDS = 1 << PAGE_W;
  localparam int DEPTH = 1 << (ARR_PG_W + PAGE_W);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem_q[j] <= '1;
    end else if (commit) begin
      for (int i = 0; i < WORDS; i++) mem_q[{commit_pg, PAGE_W'(i)}] <= img[i];
    end
  end

  assign rd_word = mem_q[rd_idx];
endmodule

// File: rtl/pgw_flash_wctl.sv
module pgw_flash_wctl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int PAGE_W   = 7,
  parameter int ARR_PG_W = 2,
  parameter int LOAD_TO  = 40000,
  parameter int PROG_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              page_err
);
  import pgw_pkg::*;

  localparam int PG_ADDR_W = ADDR_W - PAGE_W;
  localparam int POLL_HI   = DATA_W - 1;
  localparam int POLL_LO   = DATA_W / 2 - 1;
  localparam int TOG_HI    = DATA_W - 2;
  localparam int TOG_LO    = DATA_W / 2 - 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  pgw_state_e           state_q, state_d;
  logic [PG_ADDR_W-1:0] page_q;
  logic [DATA_W-1:0]    last_q, rdata_q, rdata_d, stat_word, arr_word;
  logic                 tog_q, tog_d, err_q;
  logic                 pg_match, acc, mism, load_hit, prog_hit, commit, prog_start;
  logic [DATA_W-1:0]    img [1<<PAGE_W];

  assign pg_match = (addr[ADDR_W-1:PAGE_W] == page_q);
  assign acc  = wr_en && ((state_q == ST_IDLE) || ((state_q == ST_LOAD) && pg_match));
  assign mism = wr_en && (state_q == ST_LOAD) && !pg_match;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (acc) state_d = ST_LOAD;
      ST_LOAD: if (!acc && load_hit) state_d = ST_PROG;
      ST_PROG: if (prog_hit) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign prog_start = (state_d == ST_PROG) && (state_q != ST_PROG);
  assign commit     = (state_q == ST_PROG) && prog_hit;
  assign busy       = (state_q == ST_PROG);

  always_comb begin
    stat_word          = last_q;
    stat_word[POLL_HI] = ~last_q[POLL_HI];
    stat_word[POLL_LO] = ~last_q[POLL_LO];
    stat_word[TOG_HI]  = tog_q;
    stat_word[TOG_LO]  = tog_q;
  end

  always_comb begin
    tog_d = tog_q;
    if (prog_start)         tog_d = 1'b0;
    else if (busy && rd_en) tog_d = ~tog_q;
    rdata_d = rdata_q;
    if (rd_en) rdata_d = busy ? stat_word : arr_word;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      last_q  <= '0;
      tog_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      tog_q   <= tog_d;
      rdata_q <= rdata_d;
      if (acc && (state_q == ST_IDLE)) page_q <= addr[ADDR_W-1:PAGE_W];
      if (acc)  last_q <= wdata;
      if (mism) err_q  <= 1'b1;
    end
  end

  assign rdata    = rdata_q;
  assign page_err = err_q;

  pgw_timer #(.LIMIT(LOAD_TO)) u_load_tmr (
    .clk(clk), .rst_n(rst_ns), .clr(acc), .en(state_q == ST_LOAD), .hit(load_hit)
  );

  pgw_timer #(.LIMIT(PROG_CYC)) u_prog_tmr (
    .clk(clk), .rst_n(rst_ns), .clr(!busy), .en(busy), .hit(prog_hit)
  );

  pgw_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_pbuf (
    .clk(clk), .rst_n(rst_ns), .ld_en(acc), .ld_idx(addr[PAGE_W-1:0]),
    .ld_data(wdata), .clr(commit), .img(img)
  );

  pgw_array #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .ARR_PG_W(ARR_PG_W)) u_arr (
    .clk(clk), .rst_n(rst_ns), .commit(commit), .commit_pg(page_q[ARR_PG_W-1:0]),
    .img(img), .rd_idx({addr[PAGE_W+ARR_PG_W-1:PAGE_W], addr[PAGE_W-1:0]}),
    .rd_word(arr_word)
  );
endmodule

// File: rtl/pgw_flash_chk.sv
module pgw_flash_chk #(
  parameter int DATA_W   = 16,
  parameter int PROG_CYC = 1000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              busy,
  input logic              page_err,
  input logic [DATA_W-1:0] rdata
);
  localparam int TH = DATA_W - 2;
  localparam int TL = DATA_W / 2 - 2;

  logic [31:0] run_q;
  logic        busy_q, rsp_busy_q, have_prev_q, prev_tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= '0;
      busy_q      <= 1'b0;
      rsp_busy_q  <= 1'b0;
      have_prev_q <= 1'b0;
      prev_tog_q  <= 1'b0;
    end else begin
      run_q      <= busy ? run_q + 1 : '0;
      busy_q     <= busy;
      rsp_busy_q <= rd_en && busy;
      if (busy && !busy_q) have_prev_q <= 1'b0;
      else if (rsp_busy_q) begin
        have_prev_q <= 1'b1;
        prev_tog_q  <= rdata[TL];
      end
    end
  end

  // R3: error flag never drops outside reset
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);

  // R4: programming never starts on an edge that sampled a write
  a_r4_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wr_en));

  // R6: program phase length
  a_r6_prog_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == PROG_CYC));

  // R8: both toggle bits agree in a status response
  a_r8_tog_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_busy_q |-> (rdata[TL] == rdata[TH]));

  // R8: first status read of a cycle shows 0
  a_r8_tog_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_busy_q && !have_prev_q) |-> !rdata[TL]);

  // R8: successive status reads alternate
  a_r8_tog_alt: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_busy_q && have_prev_q) |-> (rdata[TL] != prev_tog_q));

  // R10: no read, no change of read data
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind pgw_flash_wctl pgw_flash_chk #(.DATA_W(DATA_W), .PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .busy(busy), .page_err(page_err), .rdata(rdata)
);

// File: tb/pgw_flash_wctl_test.sv
module pgw_flash_wctl_test;
  localparam int LT = 8;
  localparam int PC = 20;

  logic        clk, rst_n, wr_en, rd_en, busy, page_err;
  logic [15:0] addr, wdata, rdata;
  int total, bad;
  bit finished;

  pgw_flash_wctl #(.LOAD_TO(LT), .PROG_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .page_err(page_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {addr, wdata, expected readback after programming}
  localparam logic [47:0] TBL [5] = '{
    {16'h0105, 16'h1111, 16'hBEEF},
    {16'h017F, 16'hA5C3, 16'hA5C3},
    {16'h0100, 16'h0081, 16'h0081},
    {16'h0105, 16'hBEEF, 16'hBEEF},
    {16'h0140, 16'h7E7E, 16'h7E7E}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] q);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; q = rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    int n;
    total = 0; bad = 0; finished = 0;
    wr_en = 0; rd_en = 0; addr = '0; wdata = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 busy", {15'd0, busy}, 16'd0);
    chk("R11 page_err", {15'd0, page_err}, 16'd0);
    chk("R11 rdata", rdata, 16'd0);
    rd(16'h0000, q); chk("R11 erased", q, 16'hFFFF);

    // table walk: R2 any order, overwrite
    foreach (TBL[i]) wr(TBL[i][47:32], TBL[i][31:16]);
    // R4: busy rises LT edges after last write edge
    repeat (LT - 1) @(negedge clk);
    chk("R4 before", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R4 rise", {15'd0, busy}, 16'd1);
    // R7/R8 status reads, last word 7E7E
    rd(16'h0105, q); chk("R7 R8 first", q, 16'hBEBE);
    rd(16'h0000, q); chk("R7 R8 second", q, 16'hFEFE);
    rd(16'h0000, q); chk("R8 third", q, 16'hBEBE);
    wr(16'h0101, 16'h0000);   // R9 ignored while busy
    wait_idle();
    foreach (TBL[i]) begin
      rd(TBL[i][47:32], q); chk("R2 readback", q, TBL[i][15:0]);
    end
    rd(16'h0102, q); chk("R5 unloaded", q, 16'hFFFF);
    rd(16'h0101, q); chk("R9 busy write", q, 16'hFFFF);
    rd(16'h0305, q); chk("R1 alias", q, 16'hBEEF);
    // R10 hold
    repeat (5) @(negedge clk);
    chk("R10 hold", rdata, 16'hBEEF);

    // R6: program length and array update timing
    wr(16'h0005, 16'h0F0F);
    rd(16'h0005, q); chk("R6 not yet", q, 16'hFFFF);
    while (!busy) @(negedge clk);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R6 length", 16'(n), 16'(PC));
    rd(16'h0005, q); chk("R6 committed", q, 16'h0F0F);

    // R3: foreign page load
    wr(16'h0200, 16'h0001);
    wr(16'h0280, 16'h0002);
    chk("R3 flag", {15'd0, page_err}, 16'd1);
    while (!busy) @(negedge clk);
    wait_idle();
    rd(16'h0200, q); chk("R3 kept", q, 16'h0001);
    rd(16'h0280, q); chk("R3 ignored", q, 16'hFFFF);
    chk("R3 sticky", {15'd0, page_err}, 16'd1);

    // R11 reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R11 err clr", {15'd0, page_err}, 16'd0);
    chk("R11 rdata clr", rdata, 16'd0);
    rd(16'h0200, q); chk("R11 array", q, 16'hFFFF);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule